// File: doc/BRIEF.md
# Threshold Crossing Sample Counter

This block watches a stream of signed samples and counts how many of them have a magnitude strictly above a programmable threshold. It counts over a programmable window measured in clock cycles. When a window closes, the count for that window is copied into a holding register and a one-cycle update pulse is raised. The count then restarts from zero, and the next window begins on the very next cycle.

The window timer is a down counter. It takes the period value at the start of each window and closes the window when its remaining count reaches 1. A period of P therefore gives a window of exactly P enabled clock cycles. A sample that is accepted on the closing cycle is part of the count that is published. Dropping the enable abandons the current window and clears the partial count. The holding register keeps the last published value.

Top module: `thr_cross_counter`

## Requirements
- R1: After reset, `hold_q` is 0 and `hold_upd` is 0.
- R2: The magnitude of a sample is the absolute value of its two's-complement code. The most negative code (0x8000 for 16 bits) has magnitude 2^(SAMPLE_W-1)-1 (32767 for 16 bits).
- R3: A valid sample adds 1 to the count only when its magnitude is strictly greater than `thresh`, compared as an unsigned integer. A magnitude equal to `thresh` does not count.
- R4: A cycle with `smp_valid` low adds nothing to the count, whatever `smp_data` holds.
- R5: With `en` high, a window lasts P clock cycles, where P is the value of `period`. At the edge that ends the P-th cycle, the count is loaded into `hold_q`. A `period` of 0 behaves as 1.
- R6: A valid sample that exceeds the threshold on the final cycle of a window is included in the published count.
- R7: After each load, the count restarts at 0 and the next window begins on the following cycle, with no idle cycle between windows.
- R8: `hold_upd` is high for exactly the one cycle after each load of `hold_q`. At all other times `hold_q` holds its value.
- R9: While `en` is low, no update occurs, `hold_q` keeps its value and the partial count is cleared. The first window after `en` rises lasts a full period and counts from 0.
- R10: `period` is taken at the first cycle of each window. A change made during a window takes effect from the next window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Enables counting; low abandons the current window |
| smp_valid | input | 1 | Qualifies `smp_data` in this cycle |
| smp_data | input | SAMPLE_W (16) | Signed two's-complement sample |
| thresh | input | THR_W (13) | Unsigned magnitude threshold |
| period | input | PERIOD_W (24) | Window length in clock cycles |
| hold_q | output | CNT_W (24) | Count published for the last completed window |
| hold_upd | output | 1 | One-cycle pulse when `hold_q` is loaded |

## Verification
A sample driven in cycle k of a window becomes visible only when the window closes. The published count, and the update pulse with it, appear one clock edge after the last cycle of the window. So for a window that opens at edge n, the result is due just after edge n+P-1. The bench drives each input half a cycle before an edge and runs its own magnitude-and-compare model alongside. At the falling edge that starts the next window, it checks the pulse and the published value. At every other falling edge it checks that the pulse is low and that the held value has not moved. Enable drops and mid-window period changes are checked against the same due-cycle rule, with the window length taken from the value applied at the window's first cycle.

// File: rtl/thr_pkg.sv
package thr_pkg;
  parameter int unsigned TC_SAMPLE_W = 16;
  parameter int unsigned TC_THR_W    = 13;
  parameter int unsigned TC_PERIOD_W = 24;
  parameter int unsigned TC_CNT_W    = 24;
endpackage

// File: rtl/thr_mag_cmp.sv
module thr_mag_cmp #(
  parameter int unsigned SAMPLE_W = thr_pkg::TC_SAMPLE_W,
  parameter int unsigned THR_W    = thr_pkg::TC_THR_W
) (
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic [THR_W-1:0]    thresh,
  output logic                hit
);
  localparam int unsigned MAG_W = SAMPLE_W - 1;
  localparam int unsigned CMP_W = (MAG_W > THR_W) ? MAG_W : THR_W;
  localparam logic [SAMPLE_W-1:0] MIN_CODE = {1'b1, {MAG_W{1'b0}}};

  // absolute value with the most negative code pinned to full scale
  function automatic logic [MAG_W-1:0] abs_sat(input logic [SAMPLE_W-1:0] x);
    logic [SAMPLE_W-1:0] neg;
    neg = ~x + 1'b1;
    if (x == MIN_CODE)        return '1;
    else if (x[SAMPLE_W-1])   return MAG_W'(neg);
    else                      return MAG_W'(x);
  endfunction

  function automatic logic above(input logic [MAG_W-1:0] m, input logic [THR_W-1:0] t);
    return CMP_W'(m) > CMP_W'(t);
  endfunction

  assign hit = smp_valid && above(abs_sat(smp_data), thresh);
endmodule

// File: rtl/thr_window_timer.sv
module thr_window_timer #(
  parameter int unsigned PERIOD_W = thr_pkg::TC_PERIOD_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic [PERIOD_W-1:0] period,
  output logic                win_end
);
  // tmr_q == 0 means "window starts now, take period"
  logic [PERIOD_W-1:0] tmr_q;
  logic [PERIOD_W-1:0] rem;

  assign rem     = (tmr_q == '0) ? period : tmr_q;
  assign win_end = en && (rem <= PERIOD_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)       tmr_q <= '0;
    else if (!en)     tmr_q <= '0;
    else if (win_end) tmr_q <= '0;
    else              tmr_q <= rem - PERIOD_W'(1);
  end
endmodule

// File: rtl/thr_hit_accum.sv
module thr_hit_accum #(
  parameter int unsigned CNT_W = thr_pkg::TC_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             hit,
  input  logic             win_end,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] hold_q,
  output logic             hold_upd
);
  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] c, input logic h);
    return c + CNT_W'(h);
  endfunction

  logic [CNT_W-1:0] next_sum;
  assign next_sum = bump(cnt_q, hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      hold_q   <= '0;
      hold_upd <= 1'b0;
    end else begin
      hold_upd <= 1'b0;
      if (!en) begin
        cnt_q <= '0;
      end else if (win_end) begin
        hold_q   <= next_sum;
        hold_upd <= 1'b1;
        cnt_q    <= '0;
      end else begin
        cnt_q <= next_sum;
      end
    end
  end
endmodule

// File: rtl/thr_cross_counter.sv
module thr_cross_counter #(
  parameter int unsigned SAMPLE_W = thr_pkg::TC_SAMPLE_W,
  parameter int unsigned THR_W    = thr_pkg::TC_THR_W,
  parameter int unsigned PERIOD_W = thr_pkg::TC_PERIOD_W,
  parameter int unsigned CNT_W    = thr_pkg::TC_CNT_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic [THR_W-1:0]    thresh,
  input  logic [PERIOD_W-1:0] period,
  output logic [CNT_W-1:0]    hold_q,
  output logic                hold_upd
);
  logic             hit_w;
  logic             win_end_w;
  logic [CNT_W-1:0] cnt_w;

  thr_mag_cmp #(.SAMPLE_W(SAMPLE_W), .THR_W(THR_W)) cmp_i (
    .smp_valid (smp_valid),
    .smp_data  (smp_data),
    .thresh    (thresh),
    .hit       (hit_w)
  );

  thr_window_timer #(.PERIOD_W(PERIOD_W)) tmr_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .period  (period),
    .win_end (win_end_w)
  );

  thr_hit_accum #(.CNT_W(CNT_W)) acc_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .hit      (hit_w),
    .win_end  (win_end_w),
    .cnt_q    (cnt_w),
    .hold_q   (hold_q),
    .hold_upd (hold_upd)
  );
endmodule

// File: rtl/thr_cross_chk.sv
module thr_cross_chk #(
  parameter int unsigned SAMPLE_W = thr_pkg::TC_SAMPLE_W,
  parameter int unsigned THR_W    = thr_pkg::TC_THR_W,
  parameter int unsigned CNT_W    = thr_pkg::TC_CNT_W
) (
  input logic                clk,
  input logic                rst_n,
  input logic                en,
  input logic                smp_valid,
  input logic [SAMPLE_W-1:0] smp_data,
  input logic [THR_W-1:0]    thresh,
  input logic                hit,
  input logic                win_end,
  input logic [CNT_W-1:0]    cnt_q,
  input logic [CNT_W-1:0]    hold_q,
  input logic                hold_upd
);
  localparam logic [SAMPLE_W-1:0] MIN_CODE = {1'b1, {(SAMPLE_W-1){1'b0}}};
  localparam int MAX_MAG = (2 ** (SAMPLE_W - 1)) - 1;

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> (hold_q == '0 && !hold_upd));
  // R2
  min_code_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_data == MIN_CODE) |-> (hit == (int'(thresh) < MAX_MAG)));
  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !win_end) |=> (cnt_q == $past(cnt_q) + CNT_W'($past(hit))));
  // R4
  invalid_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |-> !hit);
  // R6
  last_sample_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> (hold_q == $past(cnt_q) + CNT_W'($past(hit))));
  // R7
  clear_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> (cnt_q == '0));
  // R8
  upd_follows_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_upd |-> $past(win_end));
  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_upd |-> $stable(hold_q));
  // R9
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt_q == '0 && !hold_upd));
endmodule

bind thr_cross_counter thr_cross_chk #(
  .SAMPLE_W(SAMPLE_W), .THR_W(THR_W), .CNT_W(CNT_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (en),
  .smp_valid (smp_valid),
  .smp_data  (smp_data),
  .thresh    (thresh),
  .hit       (hit_w),
  .win_end   (win_end_w),
  .cnt_q     (cnt_w),
  .hold_q    (hold_q),
  .hold_upd  (hold_upd)
);

// File: tb/thr_cross_counter_tb_top.sv
module thr_cross_counter_tb_top;
  localparam int SW = 16;
  localparam int TW = 13;
  localparam int PW = 24;
  localparam int CW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic          smp_valid = 1'b0;
  logic [SW-1:0] smp_data = '0;
  logic [TW-1:0] thresh = '0;
  logic [PW-1:0] period = '0;
  logic [CW-1:0] hold_q;
  logic          hold_upd;

  always #4 clk = ~clk;

  thr_cross_counter dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .smp_valid(smp_valid),
    .smp_data(smp_data), .thresh(thresh), .period(period),
    .hold_q(hold_q), .hold_upd(hold_upd)
  );

  int     n_chk = 0;
  int     n_fail = 0;
  bit     pend = 0;
  longint pend_val = 0;
  string  pend_req = "";
  longint last_hold = 0;
  logic [31:0] lcg = 32'h1234_5678;
  bit     done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // reference magnitude: widen to 32 bits, negate, clip at full scale
  function automatic int ref_mag(input logic [SW-1:0] raw);
    int v;
    v = $signed(raw);
    if (v < 0) v = -v;
    if (v > 32767) v = 32767;
    return v;
  endfunction

  task automatic check_pending();
    if (pend) begin
      chk(hold_upd == 1'b1, "R8", "update pulse", hold_upd, 1);
      chk(longint'(hold_q) == pend_val, pend_req, "window count", hold_q, pend_val);
      last_hold = pend_val;
      pend = 0;
    end else begin
      chk(hold_upd == 1'b0, "R8", "no pulse", hold_upd, 0);
      chk(longint'(hold_q) == last_hold, "R8", "held value", hold_q, last_hold);
    end
  endtask

  // one window: p_port applied at first cycle, p_next from second cycle
  task automatic run_win(input int p_port, input int p_eff, input int p_next,
                         input int thr, input int mode, input string req);
    int exp = 0;
    for (int c = 0; c < p_eff; c++) begin
      @(negedge clk);
      check_pending();
      if (c == 0) begin
        period = PW'(p_port);
        thresh = TW'(thr);
      end
      if (c == 1) period = PW'(p_next);
      en = 1'b1;
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      case (mode)
        0: begin smp_data = lcg[15:0]; smp_valid = lcg[20] | lcg[21]; end
        1: begin
          smp_valid = 1'b1;
          case (c % 8)
            0: smp_data = SW'(thr);
            1: smp_data = SW'(thr + 1);
            2: smp_data = SW'(-thr);
            3: smp_data = SW'(-thr - 1);
            4: smp_data = 16'h8000;
            5: smp_data = 16'h7FFF;
            6: smp_data = 16'h0000;
            default: smp_data = 16'hFFFF;
          endcase
        end
        2: begin smp_valid = (c % 2 == 0) ? lcg[3] : 1'b0; smp_data = (c % 2 == 0) ? lcg[15:0] : 16'h8000; end
        default: begin smp_valid = (c == p_eff - 1); smp_data = 16'h8000; end
      endcase
      if (smp_valid && ref_mag(smp_data) > thr) exp++;
    end
    pend = 1;
    pend_val = exp;
    pend_req = req;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int thr_set[7] = '{0, 1, 2, 255, 4095, 8190, 8191};
    int per_set[5] = '{1, 2, 3, 5, 8};
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(hold_q == '0, "R1", "hold after reset", hold_q, 0);
    chk(hold_upd == 1'b0, "R1", "pulse after reset", hold_upd, 0);

    // sweep: R3 random, R2 edge codes, R4 invalid cycles; back-to-back R5/R7
    foreach (thr_set[i]) begin
      foreach (per_set[j]) begin
        run_win(per_set[j], per_set[j], per_set[j], thr_set[i], 0, "R3/R5/R7");
        run_win(per_set[j], per_set[j], per_set[j], thr_set[i], 1, "R2/R3");
        run_win(per_set[j], per_set[j], per_set[j], thr_set[i], 2, "R4");
      end
    end
    // R2 full-length edge-code window at highest threshold
    run_win(8, 8, 8, 8191, 1, "R2");
    // R6 only the final sample of the window exceeds
    run_win(4, 4, 4, 100, 3, "R6");
    run_win(1, 1, 1, 100, 3, "R6");
    // R5 period 0 acts as 1
    run_win(0, 1, 0, 10, 3, "R5");
    run_win(0, 1, 0, 10, 3, "R5");
    // R10 period changes mid-window
    run_win(5, 5, 3, 50, 0, "R10");
    run_win(3, 3, 3, 50, 3, "R10");

    // R9 abandon a window by dropping enable
    @(negedge clk);
    check_pending();
    period = PW'(6); en = 1'b1; smp_valid = 1'b1; smp_data = 16'h7FFF;
    @(negedge clk);
    check_pending();
    en = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(hold_upd == 1'b0, "R9", "no pulse while disabled", hold_upd, 0);
      chk(longint'(hold_q) == last_hold, "R9", "hold kept while disabled", hold_q, last_hold);
    end
    // fresh window: only the last sample hits, so a leftover count would show
    run_win(6, 6, 6, 0, 3, "R9");
    @(negedge clk);
    check_pending();
    en = 1'b0;
    smp_valid = 1'b0;

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule